// File: doc/BRIEF.md
# Chaining DMA Descriptor Fetcher

This block is the control engine of a chaining DMA. Software starts a whole chain of transfers with a single header write that gives the number of descriptors and the address of the first one. The block then walks a contiguous table of four-dword descriptors in host memory. For each descriptor it issues one read request, collects the four returned dwords and hands the length, source address, destination address and interrupt request flag to a separate data mover. It then waits for the data mover to report that the transfer has finished before it moves on to the next descriptor.

A cycle counter times the whole chain. It starts with the header write, so it includes the latency of the first descriptor fetch, and it stops on the clock edge where the data mover reports the final transfer done. An idle status output goes low while a chain runs. A header write that arrives during a chain is dropped and raises an error flag. When a descriptor that carries the interrupt flag finishes, the block emits a one-cycle pulse.

Top module: `cdma_chain_ctrl`

## Requirements
- R1: After reset, `chain_idle` is 1. `req_valid`, `desc_valid`, `hdr_err` and `irq_pulse` are 0, and `perf_count` is 0.
- R2: A `hdr_wr` with a nonzero `hdr_count`, sampled while `chain_idle` is 1, starts a chain. From the next cycle `chain_idle` is 0 and `perf_count` is 0.
- R3: The block issues one read request per descriptor, in index order n = 0 .. count-1. The address of request n is `hdr_base` with bits [3:0] forced to zero, plus 16·n. The request for descriptor n+1 is issued only after descriptor n has finished.
- R4: Each descriptor returns as four `rsp_data` beats in order. Beat 0 holds the interrupt flag in bit 31 and the byte length in bits [30:0]. Beat 1 is the source address, beat 2 is the destination address, and beat 3 is ignored. These values appear on `desc_irq`, `desc_len`, `desc_src` and `desc_dst`.
- R5: `desc_valid` stays high, with stable descriptor fields, until it is accepted by `desc_ready`.
- R6: `xfer_done` is ignored unless a descriptor has been handed over and has not yet finished. When ignored, it does not change `chain_idle`, `perf_count` or `irq_pulse`.
- R7: On the cycle after the `xfer_done` of the last descriptor, `chain_idle` is 1 and no request or descriptor is offered.
- R8: `perf_count` equals the number of rising clock edges from the edge that accepts the header to the edge that samples the final `xfer_done`. It holds that value until the next accepted header.
- R9: `irq_pulse` is high for exactly the one cycle after the `xfer_done` of a descriptor whose interrupt flag is set. It is low otherwise.
- R10: A `hdr_wr` while a chain runs does not alter the chain and sets `hdr_err` on the next cycle. `hdr_err` stays set until the next accepted header clears it.
- R11: A `hdr_wr` with `hdr_count` equal to 0 while idle is ignored. The block stays idle, issues no request and leaves `hdr_err` unchanged.
- R12: `req_valid` stays high, with a stable `req_addr`, until it is accepted by `req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_wr | input | 1 | Header write strobe |
| hdr_count | input | CNT_W | Number of descriptors in the chain |
| hdr_base | input | 32 | Byte address of the first descriptor |
| req_valid | output | 1 | Descriptor read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 32 | Byte address of the descriptor being read |
| rsp_valid | input | 1 | Read return beat valid |
| rsp_data | input | 32 | Read return dword |
| desc_valid | output | 1 | Descriptor offered to the data mover |
| desc_ready | input | 1 | Data mover accepts the descriptor |
| desc_len | output | 31 | Transfer length in bytes |
| desc_src | output | 32 | Transfer source address |
| desc_dst | output | 32 | Transfer destination address |
| desc_irq | output | 1 | Interrupt request flag of the descriptor |
| xfer_done | input | 1 | Data mover finished the current descriptor |
| chain_idle | output | 1 | High when no chain is running |
| hdr_err | output | 1 | Header was written during a running chain |
| irq_pulse | output | 1 | Flagged descriptor finished |
| perf_count | output | PERF_W | Chain duration in cycles |

## Verification
If the descriptor index is wrong, it shows up on `req_addr` at the very next request, and the length and address fields handed over for that descriptor are then wrong too. If the beat counter slips, the fields move between `desc_len`, `desc_src` and `desc_dst` on the first descriptor after the slip. Errors in the chain-end logic show up one cycle after the final `xfer_done`: `chain_idle` does not rise, or `perf_count` either keeps running or stops early. This mismatch is visible at the end of every chain across the swept counts, latencies and stall patterns.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    localparam int DW          = 32;
    localparam int LEN_W       = DW - 1;
    localparam int IRQ_BIT     = DW - 1;
    localparam int DESC_WORDS  = 4;
    localparam int DESC_USED   = 3;
    localparam int BEAT_W      = $clog2(DESC_WORDS);
    localparam int DESC_SHIFT  = $clog2(DESC_WORDS * DW / 8);

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_FETCH = 3'd1,
        SQ_WAIT  = 3'd2,
        SQ_SHOW  = 3'd3,
        SQ_RUN   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic              irq;
        logic [LEN_W-1:0]  len;
        logic [DW-1:0]     src;
        logic [DW-1:0]     dst;
    } desc_t;

    function automatic desc_t desc_unpack(input logic [DW-1:0] w_ctl,
                                          input logic [DW-1:0] w_src,
                                          input logic [DW-1:0] w_dst);
        desc_t d;
        d.irq = w_ctl[IRQ_BIT];
        d.len = w_ctl[LEN_W-1:0];
        d.src = w_src;
        d.dst = w_dst;
        return d;
    endfunction

    function automatic logic [DW-1:0] desc_addr(input logic [DW-1:0] base,
                                                 input logic [DW-1:0] idx);
        return base + (idx << DESC_SHIFT);
    endfunction

    function automatic logic [DW-1:0] align_base(input logic [DW-1:0] raw);
        return {raw[DW-1:DESC_SHIFT], {DESC_SHIFT{1'b0}}};
    endfunction

endpackage

// File: rtl/cdma_desc_asm.sv
module cdma_desc_asm
    import cdma_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          rsp_valid,
    input  logic [DW-1:0] rsp_data,
    output logic          full,
    output desc_t         desc
);
    logic [BEAT_W-1:0] beat_q;
    logic [DW-1:0]     word_q [DESC_USED];
    logic              take;

    assign take = en && rsp_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
            full   <= 1'b0;
        end else begin
            full <= take && (beat_q == BEAT_W'(DESC_WORDS - 1));
            if (take) beat_q <= beat_q + 1'b1;
        end
    end

    for (genvar w = 0; w < DESC_USED; w++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                word_q[w] <= '0;
            else if (take && beat_q == BEAT_W'(w))
                word_q[w] <= rsp_data;
        end
    end

    assign desc = desc_unpack(word_q[0], word_q[1], word_q[2]);
endmodule

// File: rtl/cdma_perf_ctr.sv
module cdma_perf_ctr #(
    parameter int PERF_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    output logic [PERF_W-1:0] count
);
    logic run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            count <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            count <= '0;
        end else if (run_q) begin
            count <= count + 1'b1;
            if (stop) run_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cdma_chain_seq.sv
module cdma_chain_seq
    import cdma_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hdr_wr,
    input  logic [CNT_W-1:0] hdr_count,
    input  logic [DW-1:0]    hdr_base,
    input  logic             req_ready,
    input  logic             asm_full,
    input  logic             desc_ready,
    input  logic             desc_irq,
    input  logic             xfer_done,
    output logic             req_valid,
    output logic [DW-1:0]    req_addr,
    output logic             asm_en,
    output logic             desc_valid,
    output logic             chain_idle,
    output logic             start,
    output logic             finish,
    output logic             hdr_err,
    output logic             irq_pulse
);
    seq_state_e       st_q;
    logic [DW-1:0]    base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] idx_q;
    logic             last;
    logic             done_ok;

    assign chain_idle = (st_q == SQ_IDLE);
    assign req_valid  = (st_q == SQ_FETCH);
    assign asm_en     = (st_q == SQ_WAIT);
    assign desc_valid = (st_q == SQ_SHOW);
    assign req_addr   = desc_addr(base_q, DW'(idx_q));
    assign last       = (idx_q == cnt_q - 1'b1);
    assign done_ok    = (st_q == SQ_RUN) && xfer_done;
    assign start      = hdr_wr && chain_idle && (hdr_count != '0);
    assign finish     = done_ok && last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= SQ_IDLE;
            base_q    <= '0;
            cnt_q     <= '0;
            idx_q     <= '0;
            hdr_err   <= 1'b0;
            irq_pulse <= 1'b0;
        end else begin
            irq_pulse <= done_ok && desc_irq;
            if (hdr_wr && !chain_idle) hdr_err <= 1'b1;
            else if (start)            hdr_err <= 1'b0;
            case (st_q)
                SQ_IDLE: if (start) begin
                    base_q <= align_base(hdr_base);
                    cnt_q  <= hdr_count;
                    idx_q  <= '0;
                    st_q   <= SQ_FETCH;
                end
                SQ_FETCH: if (req_ready)  st_q <= SQ_WAIT;
                SQ_WAIT:  if (asm_full)   st_q <= SQ_SHOW;
                SQ_SHOW:  if (desc_ready) st_q <= SQ_RUN;
                SQ_RUN: if (xfer_done) begin
                    if (last) st_q <= SQ_IDLE;
                    else begin
                        idx_q <= idx_q + 1'b1;
                        st_q  <= SQ_FETCH;
                    end
                end
                default: st_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cdma_chain_ctrl.sv
module cdma_chain_ctrl #(
    parameter int CNT_W  = 8,
    parameter int PERF_W = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       hdr_wr,
    input  logic [CNT_W-1:0]           hdr_count,
    input  logic [31:0]                hdr_base,
    output logic                       req_valid,
    input  logic                       req_ready,
    output logic [31:0]                req_addr,
    input  logic                       rsp_valid,
    input  logic [31:0]                rsp_data,
    output logic                       desc_valid,
    input  logic                       desc_ready,
    output logic [cdma_pkg::LEN_W-1:0] desc_len,
    output logic [31:0]                desc_src,
    output logic [31:0]                desc_dst,
    output logic                       desc_irq,
    input  logic                       xfer_done,
    output logic                       chain_idle,
    output logic                       hdr_err,
    output logic                       irq_pulse,
    output logic [PERF_W-1:0]          perf_count
);
    import cdma_pkg::*;

    desc_t desc;
    logic  asm_en;
    logic  asm_full;
    logic  start;
    logic  finish;

    cdma_desc_asm asm_i (
        .clk       (clk),
        .rst       (rst),
        .en        (asm_en),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data),
        .full      (asm_full),
        .desc      (desc)
    );

    cdma_chain_seq #(.CNT_W(CNT_W)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .hdr_wr     (hdr_wr),
        .hdr_count  (hdr_count),
        .hdr_base   (hdr_base),
        .req_ready  (req_ready),
        .asm_full   (asm_full),
        .desc_ready (desc_ready),
        .desc_irq   (desc.irq),
        .xfer_done  (xfer_done),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .asm_en     (asm_en),
        .desc_valid (desc_valid),
        .chain_idle (chain_idle),
        .start      (start),
        .finish     (finish),
        .hdr_err    (hdr_err),
        .irq_pulse  (irq_pulse)
    );

    cdma_perf_ctr #(.PERF_W(PERF_W)) perf_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .stop  (finish),
        .count (perf_count)
    );

    assign desc_len = desc.len;
    assign desc_src = desc.src;
    assign desc_dst = desc.dst;
    assign desc_irq = desc.irq;
endmodule

// File: rtl/cdma_chain_ctrl_chk.sv
module cdma_chain_ctrl_chk #(
    parameter int CNT_W  = 8,
    parameter int PERF_W = 32
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       hdr_wr,
    input logic [CNT_W-1:0]           hdr_count,
    input logic                       req_valid,
    input logic                       req_ready,
    input logic [31:0]                req_addr,
    input logic                       desc_valid,
    input logic                       desc_ready,
    input logic [cdma_pkg::LEN_W-1:0] desc_len,
    input logic [31:0]                desc_src,
    input logic [31:0]                desc_dst,
    input logic                       xfer_done,
    input logic                       chain_idle,
    input logic                       hdr_err,
    input logic                       irq_pulse,
    input logic [PERF_W-1:0]          perf_count
);
    AST_START_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        hdr_wr && chain_idle && hdr_count != '0 |=> !chain_idle && perf_count == '0); // R2
    AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_addr[3:0] == 4'd0); // R3
    AST_ONE_AT_A_TIME: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && desc_valid)); // R3
    AST_DESC_HOLD: assert property (@(posedge clk) disable iff (rst)
        desc_valid && !desc_ready |=> desc_valid && $stable(desc_len) && $stable(desc_src) && $stable(desc_dst)); // R5
    AST_DONE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        xfer_done && chain_idle |=> chain_idle && !irq_pulse); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        chain_idle |-> !req_valid && !desc_valid); // R7
    AST_PERF_STEP: assert property (@(posedge clk) disable iff (rst)
        !chain_idle |=> perf_count == $past(perf_count) + 1'b1); // R8
    AST_PERF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        chain_idle && !(hdr_wr && hdr_count != '0) |=> $stable(perf_count)); // R8
    AST_IRQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> $past(!chain_idle)); // R9
    AST_BUSY_HDR_ERR: assert property (@(posedge clk) disable iff (rst)
        hdr_wr && !chain_idle |=> hdr_err); // R10
    AST_ZERO_HDR: assert property (@(posedge clk) disable iff (rst)
        hdr_wr && chain_idle && hdr_count == '0 |=> chain_idle && $stable(hdr_err)); // R11
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R12
endmodule

bind cdma_chain_ctrl cdma_chain_ctrl_chk #(.CNT_W(CNT_W), .PERF_W(PERF_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .hdr_wr     (hdr_wr),
    .hdr_count  (hdr_count),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .desc_valid (desc_valid),
    .desc_ready (desc_ready),
    .desc_len   (desc_len),
    .desc_src   (desc_src),
    .desc_dst   (desc_dst),
    .xfer_done  (xfer_done),
    .chain_idle (chain_idle),
    .hdr_err    (hdr_err),
    .irq_pulse  (irq_pulse),
    .perf_count (perf_count)
);

// File: tb/cdma_chain_ctrl_tb_top.sv
module cdma_chain_ctrl_tb_top;
    localparam int CNT_W  = 8;
    localparam int PERF_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hdr_wr = 1'b0;
    logic [CNT_W-1:0]  hdr_count = '0;
    logic [31:0]       hdr_base = '0;
    logic              req_valid;
    logic              req_ready = 1'b0;
    logic [31:0]       req_addr;
    logic              rsp_valid = 1'b0;
    logic [31:0]       rsp_data = '0;
    logic              desc_valid;
    logic              desc_ready = 1'b0;
    logic [30:0]       desc_len;
    logic [31:0]       desc_src;
    logic [31:0]       desc_dst;
    logic              desc_irq;
    logic              xfer_done;
    logic              mv_done = 1'b0;
    logic              spur_done = 1'b0;
    logic              chain_idle;
    logic              hdr_err;
    logic              irq_pulse;
    logic [PERF_W-1:0] perf_count;

    assign xfer_done = mv_done | spur_done;

    always #4 clk = ~clk;

    cdma_chain_ctrl #(.CNT_W(CNT_W), .PERF_W(PERF_W)) dut_i (
        .clk(clk), .rst(rst), .hdr_wr(hdr_wr), .hdr_count(hdr_count), .hdr_base(hdr_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_len(desc_len),
        .desc_src(desc_src), .desc_dst(desc_dst), .desc_irq(desc_irq),
        .xfer_done(xfer_done), .chain_idle(chain_idle), .hdr_err(hdr_err),
        .irq_pulse(irq_pulse), .perf_count(perf_count)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Host memory image: fields derived from the descriptor address
    function automatic logic [31:0] mk_word(input logic [31:0] a, input int w);
        case (w)
            0: return {a[4] ^ a[5], 31'(a ^ 32'h0135_7000)};
            1: return a ^ 32'hA5A5_0F0F;
            2: return ~a;
            default: return 32'hDEAD_BEEF;
        endcase
    endfunction

    // chain context
    logic [31:0] ch_base = '0;
    int ch_count = 0;
    int mem_lat = 0;
    bit stall = 1'b0;
    int req_k = 0;
    int desc_k = 0;
    int done_k = 0;
    int start_edge = 0;
    int final_edge = 0;

    function automatic logic [31:0] exp_addr(input int k);
        return {ch_base[31:4], 4'b0} + 32'(k * 16);
    endfunction

    // memory model
    int beats_left = 0;
    int beat_i = 0;
    int wait_cnt = 0;
    logic [31:0] cur_addr = '0;
    bit req_hold = 1'b0;
    logic [31:0] held_addr = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (req_hold)
                check(req_valid && req_addr == held_addr, "R12", {32'(req_valid), req_addr}, {32'd1, held_addr});
            if (beats_left > 0) begin
                if (wait_cnt > 0) begin
                    wait_cnt--;
                    rsp_valid = 1'b0;
                end else begin
                    rsp_valid = 1'b1;
                    rsp_data  = mk_word(cur_addr, beat_i);
                    beat_i++;
                    beats_left--;
                end
            end else begin
                rsp_valid = 1'b0;
            end
            req_ready = stall ? (cyc % 3 != 0) : 1'b1;
            req_hold  = req_valid && !req_ready;
            held_addr = req_addr;
            if (req_valid && req_ready) begin
                check(req_addr == exp_addr(req_k), "R3", req_addr, exp_addr(req_k));
                check(req_k == done_k, "R3", req_k, done_k);
                cur_addr   = req_addr;
                beats_left = 4;
                beat_i     = 0;
                wait_cnt   = mem_lat;
                req_k++;
            end
        end
    end

    // data mover model
    int run_left = 0;
    bit cur_irq = 1'b0;
    bit irq_due_v = 1'b0;
    bit irq_due = 1'b0;
    bit d_hold = 1'b0;
    logic [94:0] held_desc = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (irq_due_v)
                check(irq_pulse == irq_due, "R9", irq_pulse, irq_due);
            else if (irq_pulse)
                check(1'b0, "R9", irq_pulse, 0);
            irq_due_v = 1'b0;
            if (d_hold)
                check(desc_valid && {desc_len, desc_src, desc_dst} == held_desc, "R5",
                      longint'(desc_valid), 1);
            mv_done = 1'b0;
            if (run_left > 0) begin
                run_left--;
                if (run_left == 0) begin
                    mv_done   = 1'b1;
                    irq_due_v = 1'b1;
                    irq_due   = cur_irq;
                    if (done_k + 1 == ch_count) final_edge = cyc + 1;
                    done_k++;
                end
            end
            desc_ready = (run_left == 0) && !mv_done && (stall ? (cyc % 2 == 0) : 1'b1);
            d_hold    = desc_valid && !desc_ready;
            held_desc = {desc_len, desc_src, desc_dst};
            if (desc_valid && desc_ready) begin
                logic [31:0] a;
                logic [31:0] w0;
                a  = exp_addr(desc_k);
                w0 = mk_word(a, 0);
                check(desc_len == w0[30:0], "R4", desc_len, w0[30:0]);
                check(desc_irq == w0[31], "R4", desc_irq, w0[31]);
                check(desc_src == mk_word(a, 1), "R4", desc_src, mk_word(a, 1));
                check(desc_dst == mk_word(a, 2), "R4", desc_dst, mk_word(a, 2));
                cur_irq  = w0[31];
                run_left = 1 + (desc_k % 3);
                desc_k++;
            end
        end
    end

    task automatic run_chain(input logic [31:0] base, input int cnt, input int lat,
                             input bit stl, input bit inject);
        int guard;
        ch_base = base; ch_count = cnt; mem_lat = lat; stall = stl;
        req_k = 0; desc_k = 0; done_k = 0;
        @(negedge clk);
        hdr_base = base; hdr_count = CNT_W'(cnt); hdr_wr = 1'b1;
        start_edge = cyc + 1;
        @(negedge clk);
        hdr_wr = 1'b0;
        check(!chain_idle, "R2", chain_idle, 0);
        check(perf_count == 0, "R2", perf_count, 0);
        check(!hdr_err, "R10", hdr_err, 0);
        if (inject) begin
            @(negedge clk);
            hdr_base = 32'h7777_0000; hdr_count = 8'd1; hdr_wr = 1'b1;
            @(negedge clk);
            hdr_wr = 1'b0;
            check(hdr_err, "R10", hdr_err, 1);
            check(!chain_idle, "R10", chain_idle, 0);
        end
        guard = 0;
        while (done_k < cnt && guard < 3000) begin
            @(posedge clk);
            guard++;
        end
        if (guard >= 3000) check(1'b0, "R7", done_k, cnt);
        @(negedge clk);
        check(chain_idle, "R7", chain_idle, 1);
        check(!req_valid && !desc_valid, "R7", {req_valid, desc_valid}, 0);
        check(perf_count == PERF_W'(final_edge - start_edge), "R8", perf_count, final_edge - start_edge);
        check(req_k == cnt && desc_k == cnt, "R3", req_k, cnt);
        if (inject) check(hdr_err, "R10", hdr_err, 1);
        repeat (3) @(negedge clk);
        check(perf_count == PERF_W'(final_edge - start_edge), "R8", perf_count, final_edge - start_edge);
    endtask

    initial begin
        logic [PERF_W-1:0] pc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(chain_idle, "R1", chain_idle, 1);
        check(!req_valid && !desc_valid, "R1", {req_valid, desc_valid}, 0);
        check(!hdr_err && !irq_pulse, "R1", {hdr_err, irq_pulse}, 0);
        check(perf_count == 0, "R1", perf_count, 0);

        // R11: zero-count header
        hdr_count = '0; hdr_base = 32'h0000_4000; hdr_wr = 1'b1;
        @(negedge clk);
        hdr_wr = 1'b0;
        check(chain_idle, "R11", chain_idle, 1);
        check(!req_valid && !hdr_err, "R11", {req_valid, hdr_err}, 0);
        @(negedge clk);
        check(!req_valid, "R11", req_valid, 0);

        // sweep chain length, memory latency, stall pattern, base alignment
        for (int c = 1; c <= 5; c++)
            for (int l = 0; l < 2; l++)
                for (int s = 0; s < 2; s++)
                    run_chain(32'h1000_0000 + 32'(c * 32'h340) + 32'(l * 5) + 32'(s * 32'h20),
                              c, l * 3, s[0], 1'b0);

        // R10: header during a running chain, then cleared by the next chain
        run_chain(32'h2000_0010, 3, 1, 1'b1, 1'b1);
        run_chain(32'h2100_0000, 2, 0, 1'b0, 1'b0);

        // R6: stray done while idle
        pc = perf_count;
        spur_done = 1'b1;
        @(negedge clk);
        spur_done = 1'b0;
        check(chain_idle, "R6", chain_idle, 1);
        check(!irq_pulse, "R6", irq_pulse, 0);
        check(perf_count == pc, "R6", perf_count, pc);
        @(negedge clk);
        check(!req_valid && perf_count == pc, "R6", perf_count, pc);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule